// File: doc/BRIEF.md
# Page Program Buffer and Sequencer

This block sits behind the serial command decoder of a small-sector serial flash model. It handles the page-program command. When a program command opens, the block latches the target page and the first in-page offset. It then stores each incoming data byte in a local page buffer and marks that offset as filled. The offset advances after every byte and wraps inside the page, so it never reaches the next page. If more bytes arrive than a page holds, the later bytes overwrite the earlier ones at the same offsets.

When chip select rises, the front end reports whether the frame ended on a whole byte. The block starts a timed program cycle only if four conditions all hold: the frame ended on a whole byte, the write-enable state was set, at least one data byte arrived, and the page is not locked out. The cycle walks the filled offsets starting from the first offset. For each one it reads the old array byte and writes back the old byte ANDed with the buffered byte. Each byte takes a fixed number of clock cycles. Busy stays high for the whole cycle, and a one-cycle pulse clears the write-enable latch as the cycle ends.

Top module: `pgm_page_prog`

## Requirements
- R1: After reset, `busy`, `arr_rd_en`, `arr_wr_en` and `wen_clr` are all low.
- R2: If `wen_in` is low when `cmd_start` pulses, the command is ignored: no cycle starts on the following `cs_rise`, there is no array write and there is no `wen_clr` pulse.
- R3: Data byte k of a command is stored at in-page offset (start_addr[7:0] + k) mod 256. The page number (start_addr[16:8]) stays fixed for the whole command, so offset 8'hFF is followed by 8'h00 of the same page.
- R4: When more than 256 bytes arrive, the array receives the last byte sent to each offset, and the cycle covers 256 bytes.
- R5: Only offsets that received data are written to the array, with one write strobe per filled offset. All other bytes of the page and of the array keep their value.
- R6: Each written array byte equals the old array byte ANDed with the buffered byte, so bits only go from 1 to 0.
- R7: A cycle starts only on a `cs_rise` with `cs_aligned` high. When `cs_aligned` is low, the command is dropped with no busy and no write.
- R8: At `cs_rise`, `lock_addr` presents the page base address ({page, 8'h00}). If `lock_hit` is high there, no cycle starts.
- R9: `busy` rises in the clock cycle after the accepted `cs_rise`. It stays high for exactly n × BYTE_CYC cycles, where n is min(bytes received, 256).
- R10: `wen_clr` pulses for exactly one cycle, in the last busy cycle of each completed program cycle, and never for a dropped command.
- R11: While `busy` is high, `cmd_start`, `byte_vld` and `cs_rise` have no effect. The running cycle neither lengthens nor changes page, and no second cycle follows.
- R12: A new accepted command clears the filled-offset mask. The next cycle writes only the offsets of that new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse: a program command with its address has been decoded |
| start_addr | input | 17 | Byte address given with the command |
| byte_vld | input | 1 | One-cycle pulse: a data byte is complete |
| byte_data | input | 8 | Data byte value |
| cs_rise | input | 1 | One-cycle pulse: chip select went high |
| cs_aligned | input | 1 | High when the frame ended right after a whole byte |
| wen_in | input | 1 | Current write-enable latch state |
| lock_addr | output | 17 | Address sent to the lockout query |
| lock_hit | input | 1 | Lockout query answer for `lock_addr` |
| busy | output | 1 | Program cycle in progress |
| arr_rd_en | output | 1 | Array read request; data is returned on the next cycle |
| arr_addr | output | 17 | Array address for read and write |
| arr_rd_data | input | 8 | Array read data, one cycle after `arr_rd_en` |
| arr_wr_en | output | 1 | Array write strobe |
| arr_wr_data | output | 8 | Merged byte to write |
| wen_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The final array write of a cycle and the write-enable clear pulse fall in the same clock cycle. The bench counts both strobes at the same clock edge and checks that busy drops on the next cycle. A second overlap is provoked on purpose: a new command, data bytes and another chip-select rise are injected while a cycle is running. The bench judges this overlap by the exact busy length, by the bytes reaching the running page only, and by the absence of any write at the injected address.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_FILL = 2'd1,
      PG_RUN  = 2'd2
   } pg_state_e;
endpackage

// File: rtl/pgm_page_buf.sv
module pgm_page_buf #(
   parameter int PAGE_BYTES = 256,
   parameter int DATA_W     = 8,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int CNT_W     = OFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [OFS_W-1:0]  start_ofs,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFS_W-1:0]  rd_ofs,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic [CNT_W-1:0]  fill_cnt
);
   logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_q;
   logic [OFS_W-1:0]      wofs_q;
   logic [CNT_W-1:0]      cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wofs_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         wofs_q <= start_ofs;
         cnt_q  <= '0;
      end else if (wr_en) begin
         wofs_q <= wofs_q + 1'b1;
         if (cnt_q != CNT_W'(PAGE_BYTES))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !clr)
         mem_q[wofs_q] <= wr_data;
   end

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_vld
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vld_q[g] <= 1'b0;
         else if (clr)
            vld_q[g] <= 1'b0;
         else if (wr_en && (wofs_q == OFS_W'(g)))
            vld_q[g] <= 1'b1;
      end
   end

   assign rd_data  = mem_q[rd_ofs];
   assign rd_vld   = vld_q[rd_ofs];
   assign fill_cnt = cnt_q;

   // R3
   fill_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> vld_q[$past(wofs_q)]);
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
   import pgm_pkg::*;
#(
   parameter int OFS_W    = 8,
   parameter int PAGE_W   = 9,
   parameter int DATA_W   = 8,
   parameter int BYTE_CYC = 6000,
   localparam int CNT_W   = OFS_W + 1,
   localparam int ADDR_W  = PAGE_W + OFS_W,
   localparam int TMR_W   = $clog2(BYTE_CYC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              wen_in,
   input  logic              cs_rise,
   input  logic              cs_aligned,
   input  logic              lock_hit,
   output logic [ADDR_W-1:0] lock_addr,
   input  logic [CNT_W-1:0]  fill_cnt,
   input  logic              buf_vld,
   input  logic [DATA_W-1:0] buf_data,
   output logic              buf_clr,
   output logic              fill_en,
   output logic [OFS_W-1:0]  rd_ofs,
   output logic              busy,
   output logic              arr_rd_en,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rd_data,
   output logic              arr_wr_en,
   output logic [DATA_W-1:0] arr_wr_data,
   output logic              wen_clr
);
   pg_state_e          st_q;
   logic [PAGE_W-1:0]  page_q;
   logic [OFS_W-1:0]   sofs_q;
   logic [CNT_W-1:0]   slot_q;
   logic [CNT_W-1:0]   n_q;
   logic [TMR_W-1:0]   tmr_q;
   logic [DATA_W-1:0]  old_q;
   logic [OFS_W-1:0]   walk_ofs;
   logic               slot_end;
   logic               last_slot;
   logic               go;

   assign walk_ofs  = sofs_q + slot_q[OFS_W-1:0];
   assign slot_end  = (st_q == PG_RUN) && (tmr_q == TMR_W'(BYTE_CYC - 1));
   assign last_slot = (slot_q == n_q - 1'b1);
   assign buf_clr   = (st_q == PG_IDLE) && cmd_start && wen_in;
   assign fill_en   = (st_q == PG_FILL);
   assign go        = (st_q == PG_FILL) && cs_rise && cs_aligned && wen_in
                      && !lock_hit && (fill_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PG_IDLE;
         page_q <= '0;
         sofs_q <= '0;
         slot_q <= '0;
         n_q    <= '0;
         tmr_q  <= '0;
         old_q  <= '0;
      end else begin
         unique case (st_q)
            PG_IDLE: begin
               if (buf_clr) begin
                  st_q   <= PG_FILL;
                  page_q <= start_addr[ADDR_W-1:OFS_W];
                  sofs_q <= start_addr[OFS_W-1:0];
               end
            end
            PG_FILL: begin
               if (go) begin
                  st_q   <= PG_RUN;
                  n_q    <= fill_cnt;
                  slot_q <= '0;
                  tmr_q  <= '0;
               end else if (cs_rise) begin
                  st_q <= PG_IDLE;
               end
            end
            PG_RUN: begin
               if (tmr_q == TMR_W'(1))
                  old_q <= arr_rd_data;
               if (slot_end) begin
                  tmr_q <= '0;
                  if (last_slot)
                     st_q <= PG_IDLE;
                  else
                     slot_q <= slot_q + 1'b1;
               end else begin
                  tmr_q <= tmr_q + 1'b1;
               end
            end
            default: st_q <= PG_IDLE;
         endcase
      end
   end

   assign busy        = (st_q == PG_RUN);
   assign rd_ofs      = walk_ofs;
   assign arr_addr    = {page_q, walk_ofs};
   assign arr_rd_en   = busy && (tmr_q == '0);
   assign arr_wr_en   = slot_end;
   assign arr_wr_data = old_q & buf_data;
   assign wen_clr     = slot_end && last_slot;
   assign lock_addr   = {page_q, {OFS_W{1'b0}}};

   // R9
   run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_rise && cs_aligned && !lock_hit));
   // R10
   wen_clr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wen_clr |=> !busy);
   // R3
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(arr_addr[ADDR_W-1:OFS_W]));
   // R5
   wr_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_en |-> buf_vld);
   // R6
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({arr_rd_en, arr_wr_en}));
endmodule

// File: rtl/pgm_page_prog.sv
module pgm_page_prog #(
   parameter int PAGE_BYTES = 256,
   parameter int PAGE_CNT   = 512,
   parameter int DATA_W     = 8,
   parameter int BYTE_CYC   = 6000,
   localparam int OFS_W     = $clog2(PAGE_BYTES),
   localparam int PAGE_W    = $clog2(PAGE_CNT),
   localparam int ADDR_W    = OFS_W + PAGE_W,
   localparam int CNT_W     = OFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              cs_rise,
   input  logic              cs_aligned,
   input  logic              wen_in,
   output logic [ADDR_W-1:0] lock_addr,
   input  logic              lock_hit,
   output logic              busy,
   output logic              arr_rd_en,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rd_data,
   output logic              arr_wr_en,
   output logic [DATA_W-1:0] arr_wr_data,
   output logic              wen_clr
);
   if ((1 << OFS_W) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((1 << PAGE_W) != PAGE_CNT) begin : g_bad_cnt
      $error("PAGE_CNT must be a power of two");
   end
   if (BYTE_CYC < 3) begin : g_bad_cyc
      $error("BYTE_CYC must be at least 3");
   end

   logic              buf_clr;
   logic              fill_en;
   logic [OFS_W-1:0]  rd_ofs;
   logic [DATA_W-1:0] buf_data;
   logic              buf_vld;
   logic [CNT_W-1:0]  fill_cnt;

   pgm_page_buf #(
      .PAGE_BYTES (PAGE_BYTES),
      .DATA_W     (DATA_W)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (buf_clr),
      .start_ofs (start_addr[OFS_W-1:0]),
      .wr_en     (byte_vld && fill_en),
      .wr_data   (byte_data),
      .rd_ofs    (rd_ofs),
      .rd_data   (buf_data),
      .rd_vld    (buf_vld),
      .fill_cnt  (fill_cnt)
   );

   pgm_seq #(
      .OFS_W    (OFS_W),
      .PAGE_W   (PAGE_W),
      .DATA_W   (DATA_W),
      .BYTE_CYC (BYTE_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .start_addr  (start_addr),
      .wen_in      (wen_in),
      .cs_rise     (cs_rise),
      .cs_aligned  (cs_aligned),
      .lock_hit    (lock_hit),
      .lock_addr   (lock_addr),
      .fill_cnt    (fill_cnt),
      .buf_vld     (buf_vld),
      .buf_data    (buf_data),
      .buf_clr     (buf_clr),
      .fill_en     (fill_en),
      .rd_ofs      (rd_ofs),
      .busy        (busy),
      .arr_rd_en   (arr_rd_en),
      .arr_addr    (arr_addr),
      .arr_rd_data (arr_rd_data),
      .arr_wr_en   (arr_wr_en),
      .arr_wr_data (arr_wr_data),
      .wen_clr     (wen_clr)
   );

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!arr_wr_en && !arr_rd_en && !wen_clr));
endmodule

// File: tb/pgm_page_prog_tb_top.sv
module pgm_page_prog_tb_top;
   localparam int BC = 4;

   typedef struct packed {
      logic [16:0] addr;
      logic [9:0]  nb;
      logic [7:0]  seed;
      logic        al;
      logic        we;
      logic        lk;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{17'h00310, 10'd4,   8'h11, 1'b1, 1'b1, 1'b0},
      '{17'h003FE, 10'd5,   8'h2C, 1'b1, 1'b1, 1'b0},
      '{17'h00312, 10'd3,   8'hC3, 1'b1, 1'b1, 1'b0},
      '{17'h1A0F0, 10'd260, 8'h5A, 1'b1, 1'b1, 1'b0},
      '{17'h04020, 10'd6,   8'h00, 1'b1, 1'b0, 1'b0},
      '{17'h05040, 10'd6,   8'h00, 1'b0, 1'b1, 1'b0},
      '{17'h06080, 10'd6,   8'h00, 1'b1, 1'b1, 1'b1},
      '{17'h1FFFF, 10'd1,   8'h96, 1'b1, 1'b1, 1'b0}
   };
   localparam string TAGS [8] = '{"R3", "R3", "R6", "R4", "R2", "R7", "R8", "R5"};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [16:0] start_addr = '0;
   logic        byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        cs_rise = 1'b0;
   logic        cs_aligned = 1'b0;
   logic        wen_in = 1'b0;
   logic [16:0] lock_addr;
   logic        lock_hit = 1'b0;
   logic        busy;
   logic        arr_rd_en;
   logic [16:0] arr_addr;
   logic [7:0]  arr_rd_data = 8'hFF;
   logic        arr_wr_en;
   logic [7:0]  arr_wr_data;
   logic        wen_clr;

   int checks = 0;
   int fails  = 0;
   int wr_cnt = 0;
   int clr_cnt = 0;
   logic [7:0] mem [int];
   logic [7:0] ref_m [int];

   always #2.5 clk = ~clk;

   pgm_page_prog #(.BYTE_CYC(BC)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
      .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
      .cs_aligned(cs_aligned), .wen_in(wen_in), .lock_addr(lock_addr),
      .lock_hit(lock_hit), .busy(busy), .arr_rd_en(arr_rd_en), .arr_addr(arr_addr),
      .arr_rd_data(arr_rd_data), .arr_wr_en(arr_wr_en), .arr_wr_data(arr_wr_data),
      .wen_clr(wen_clr)
   );

   function automatic logic [7:0] rd_mem(int a);
      return mem.exists(a) ? mem[a] : 8'hFF;
   endfunction
   function automatic logic [7:0] rd_ref(int a);
      return ref_m.exists(a) ? ref_m[a] : 8'hFF;
   endfunction
   function automatic logic [7:0] dat(logic [7:0] seed, int i);
      logic [7:0] m;
      m = 8'(i * 37);
      return seed ^ m ^ 8'(i >> 8);
   endfunction

   always @(posedge clk) begin
      if (arr_rd_en) arr_rd_data <= rd_mem(int'(arr_addr));
      if (arr_wr_en) begin
         mem[int'(arr_addr)] = arr_wr_data;
         wr_cnt++;
      end
      if (wen_clr) clr_cnt++;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic count_busy(output int c);
      c = 0;
      while (busy && c < 3000) begin
         c++;
         @(negedge clk);
      end
   endtask

   task automatic run_cmd(input vec_t v, input string tag, input logic [16:0] chk_lock);
      int c;
      @(negedge clk);
      cmd_start = 1'b1; start_addr = v.addr; wen_in = v.we;
      @(negedge clk);
      cmd_start = 1'b0;
      for (int i = 0; i < int'(v.nb); i++) begin
         byte_vld = 1'b1; byte_data = dat(v.seed, i);
         @(negedge clk);
      end
      byte_vld = 1'b0;
      cs_rise = 1'b1; cs_aligned = v.al; lock_hit = v.lk;
      if (v.we) check("R8", {tag, " lock query address"}, int'(lock_addr), int'(chk_lock));
      @(negedge clk);
      cs_rise = 1'b0; lock_hit = 1'b0;
      count_busy(c);
      begin
         int n;
         logic go;
         go = v.al && v.we && !v.lk;
         n = (int'(v.nb) > 256) ? 256 : int'(v.nb);
         check("R9", {tag, " busy length"}, c, go ? n * BC : 0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "busy in reset", int'(busy), 0);
      check("R1", "write strobe in reset", int'(arr_wr_en), 0);
      check("R1", "wen_clr in reset", int'(wen_clr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "busy after reset", int'(busy), 0);

      for (int k = 0; k < 8; k++) begin
         vec_t v;
         logic [7:0] pbuf [256];
         logic       pv [256];
         int w0, c0, nexp, base;
         logic go;
         v = VECS[k];
         base = int'({v.addr[16:8], 8'h00});
         go = v.al && v.we && !v.lk;
         for (int o = 0; o < 256; o++) pv[o] = 1'b0;
         for (int i = 0; i < int'(v.nb); i++) begin
            pbuf[8'(int'(v.addr[7:0]) + i)] = dat(v.seed, i);
            pv[8'(int'(v.addr[7:0]) + i)] = 1'b1;
         end
         nexp = 0;
         if (go)
            for (int o = 0; o < 256; o++)
               if (pv[o]) begin
                  ref_m[base + o] = rd_ref(base + o) & pbuf[o];
                  nexp++;
               end
         w0 = wr_cnt; c0 = clr_cnt;
         run_cmd(v, TAGS[k], 17'(base));
         check("R5", {TAGS[k], " write strobe count"}, wr_cnt - w0, nexp);
         check("R10", {TAGS[k], " wen_clr pulses"}, clr_cnt - c0, go ? 1 : 0);
         begin
            int bad;
            bad = 0;
            for (int o = 0; o < 256; o++)
               if (rd_mem(base + o) !== rd_ref(base + o)) bad++;
            check(TAGS[k], "page bytes differing from expected", bad, 0);
         end
      end

      // R12: page 3 now holds only the bytes of vectors 0..2; offset 0x20 never written
      check("R12", "unwritten offset in reused page", int'(rd_mem(32'h00320)), 8'hFF);

      // R11: inject a command, bytes and a chip-select rise during a running cycle
      begin
         int c, w0, c0;
         w0 = wr_cnt; c0 = clr_cnt;
         @(negedge clk);
         cmd_start = 1'b1; start_addr = 17'h02200; wen_in = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0;
         byte_vld = 1'b1; byte_data = 8'h0F;
         @(negedge clk);
         byte_data = 8'h3C;
         @(negedge clk);
         byte_vld = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1;
         @(negedge clk);
         cs_rise = 1'b0;
         cmd_start = 1'b1; start_addr = 17'h07700;
         @(negedge clk);
         cmd_start = 1'b0; byte_vld = 1'b1; byte_data = 8'h00;
         @(negedge clk);
         byte_vld = 1'b0; cs_rise = 1'b1;
         @(negedge clk);
         cs_rise = 1'b0;
         count_busy(c);
         check("R11", "busy length with injected traffic", c + 3, 2 * BC);
         repeat (10) @(negedge clk);
         check("R11", "no second cycle", int'(busy), 0);
         check("R11", "injected address untouched", int'(rd_mem(32'h07700)), 8'hFF);
         check("R11", "running page byte 0", int'(rd_mem(32'h02200)), 8'h0F);
         check("R11", "running page byte 1", int'(rd_mem(32'h02201)), 8'h3C);
         check("R10", "one wen_clr for running cycle", clr_cnt - c0, 1);
         check("R11", "writes of running cycle", wr_cnt - w0, 2);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule